// File: doc/BRIEF.md
# Modem Handshake Control with Internal Loopback

This block owns the modem control register of a serial port and turns its bits into the four active-low handshake outputs: data-terminal-ready, request-to-send and two general-purpose outputs. A control bit selects an internal loopback mode. In that mode the external handshake pins fall to their inactive (high) level and the control bits are routed straight back into the modem status inputs. At the same time the serial transmit stream is turned around into the receive path while the serial output pin idles at mark.

The status side samples the four active-low status pins (clear-to-send, data-set-ready, ring indicator, carrier detect) through a two-flop synchroniser. It reports their active-high levels together with four change flags. Each change flag latches a transition and is cleared by a read of the status register. A one-bit address selects between the control register and the status register on a simple read/write port.

Top module: `mdm_ctl_loop`

## Requirements
- R1: The control register resets to 0. A write with `addr`=0 stores `wdata[4:0]`. A read with `addr`=0 returns those five bits in `rdata[4:0]`, with all higher bits 0. Field positions: bit0 terminal-ready, bit1 request-to-send, bit2 general output 1, bit3 general output 2, bit4 loopback enable.
- R2: Outside loopback, `dtr_n` is low when control bit0 is 1 and high when it is 0.
- R3: Outside loopback, `rts_n` is low when control bit1 is 1 and high when it is 0.
- R4: Outside loopback, `out1_n` and `out2_n` are the inverses of control bits 2 and 3.
- R5: In loopback, the status levels are taken from the control register. Clear-to-send (status bit4) follows control bit1, data-set-ready (bit5) follows bit0, ring (bit6) follows bit2 and carrier (bit7) follows bit3. Each follows the control register in the cycle after the write.
- R6: In loopback, `dtr_n`, `rts_n`, `out1_n`, `out2_n` and `txd_pin` are all held high.
- R7: In loopback, `rx_ser` equals `tx_ser`. Outside loopback, `rx_ser` equals `rxd_pin` and `txd_pin` equals `tx_ser`.
- R8: Outside loopback, status bits 4..7 are the inverses of `cts_n`, `dsr_n`, `ri_n` and `dcd_n`. A pin change is seen two clock edges after it is sampled.
- R9: A status change flag is set one edge after the status level it watches changes. Status bits 0, 1 and 3 watch for any change of clear-to-send, data-set-ready and carrier. Status bit 2 watches only for ring going from 1 to 0. The flags reset to 0.
- R10: A read with `addr`=1 returns the current flags and levels, and clears the flags at that clock edge. A change detected at the same edge leaves its flag set.
- R11: `rdata` is 0 whenever `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 1 | 0 selects control, 1 selects status |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, 0 when not reading |
| tx_ser | input | 1 | Serial stream from the transmitter |
| rx_ser | output | 1 | Serial stream to the receiver |
| txd_pin | output | 1 | Serial output pin |
| rxd_pin | input | 1 | Serial input pin |
| dtr_n | output | 1 | Terminal-ready pin, active low |
| rts_n | output | 1 | Request-to-send pin, active low |
| out1_n | output | 1 | General output 1 pin, active low |
| out2_n | output | 1 | General output 2 pin, active low |
| cts_n | input | 1 | Clear-to-send pin, active low |
| dsr_n | input | 1 | Data-set-ready pin, active low |
| ri_n | input | 1 | Ring pin, active low |
| dcd_n | input | 1 | Carrier pin, active low |

## Verification
A status read and a new change flag can land on the same clock edge: the read tries to clear the flags while the detector tries to set one. The bench provokes this by changing a status pin and then reading the status exactly two cycles later, which is the edge at which the synchronised change reaches the detector. It also does this by writing a control bit in loopback just before a status read. The behavioural model keeps the flag set in both cases, and a second read must still show it.

// File: rtl/mdm_pkg.sv
package mdm_pkg;

    localparam int LINE_W = 4;

    typedef struct packed {
        logic loop;
        logic out2;
        logic out1;
        logic rts;
        logic dtr;
    } mdm_ctrl_t;

    localparam int CTRL_W = $bits(mdm_ctrl_t);

    typedef struct packed {
        logic dcd;
        logic ri;
        logic dsr;
        logic cts;
    } mdm_lines_t;

    typedef enum logic {
        SEL_CTRL = 1'b0,
        SEL_STAT = 1'b1
    } mdm_sel_e;

    // Status levels seen when the port talks to itself
    function automatic mdm_lines_t loop_lines(input mdm_ctrl_t c);
        mdm_lines_t l;
        l.cts = c.rts;
        l.dsr = c.dtr;
        l.ri  = c.out1;
        l.dcd = c.out2;
        return l;
    endfunction

    // Events that latch a change flag: any edge, except ring (trailing only)
    function automatic mdm_lines_t line_events(input mdm_lines_t prev, input mdm_lines_t now);
        mdm_lines_t e;
        e.cts = prev.cts ^ now.cts;
        e.dsr = prev.dsr ^ now.dsr;
        e.dcd = prev.dcd ^ now.dcd;
        e.ri  = prev.ri & ~now.ri;
        return e;
    endfunction

endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage[s] <= '0;
                else     stage[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage[s] <= '0;
                else     stage[s] <= stage[s-1];
            end
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/mdm_route.sv
module mdm_route
    import mdm_pkg::*;
(
    input  mdm_ctrl_t  ctrl,
    input  mdm_lines_t ext_lines,
    input  logic       tx_ser,
    input  logic       rxd_pin,
    output logic       rx_ser,
    output logic       txd_pin,
    output logic       dtr_n,
    output logic       rts_n,
    output logic       out1_n,
    output logic       out2_n,
    output mdm_lines_t lines_now
);
    always_comb begin
        if (ctrl.loop) begin
            dtr_n     = 1'b1;
            rts_n     = 1'b1;
            out1_n    = 1'b1;
            out2_n    = 1'b1;
            txd_pin   = 1'b1;
            rx_ser    = tx_ser;
            lines_now = loop_lines(ctrl);
        end else begin
            dtr_n     = ~ctrl.dtr;
            rts_n     = ~ctrl.rts;
            out1_n    = ~ctrl.out1;
            out2_n    = ~ctrl.out2;
            txd_pin   = tx_ser;
            rx_ser    = rxd_pin;
            lines_now = ext_lines;
        end
    end
endmodule

// File: rtl/mdm_delta.sv
module mdm_delta
    import mdm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  mdm_lines_t lines_now,
    input  logic       clr,
    output mdm_lines_t lines_q,
    output mdm_lines_t flags
);
    mdm_lines_t evt;

    always_comb evt = line_events(lines_q, lines_now);

    always_ff @(posedge clk) begin
        if (rst) begin
            lines_q <= '0;
            flags   <= '0;
        end else begin
            lines_q <= lines_now;
            flags   <= (clr ? mdm_lines_t'('0) : flags) | evt;
        end
    end
endmodule

// File: rtl/mdm_ctl_loop.sv
module mdm_ctl_loop
    import mdm_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              tx_ser,
    output logic              rx_ser,
    output logic              txd_pin,
    input  logic              rxd_pin,
    output logic              dtr_n,
    output logic              rts_n,
    output logic              out1_n,
    output logic              out2_n,
    input  logic              cts_n,
    input  logic              dsr_n,
    input  logic              ri_n,
    input  logic              dcd_n
);
    localparam int STAT_W = 2 * LINE_W;

    mdm_ctrl_t  ctrl_q;
    mdm_lines_t pin_lines;
    mdm_lines_t ext_lines;
    mdm_lines_t lines_now;
    mdm_lines_t lines_q;
    mdm_lines_t flags;
    logic       wr_ctrl;
    logic       rd_stat;

    assign wr_ctrl = wr_en && (mdm_sel_e'(addr) == SEL_CTRL);
    assign rd_stat = rd_en && (mdm_sel_e'(addr) == SEL_STAT);

    always_ff @(posedge clk) begin
        if (rst)          ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= mdm_ctrl_t'(wdata[CTRL_W-1:0]);
    end

    assign pin_lines = mdm_lines_t'(~{dcd_n, ri_n, dsr_n, cts_n});

    mdm_sync #(.W(LINE_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_lines),
        .q   (ext_lines)
    );

    mdm_route u_route (
        .ctrl      (ctrl_q),
        .ext_lines (ext_lines),
        .tx_ser    (tx_ser),
        .rxd_pin   (rxd_pin),
        .rx_ser    (rx_ser),
        .txd_pin   (txd_pin),
        .dtr_n     (dtr_n),
        .rts_n     (rts_n),
        .out1_n    (out1_n),
        .out2_n    (out2_n),
        .lines_now (lines_now)
    );

    mdm_delta u_delta (
        .clk       (clk),
        .rst       (rst),
        .lines_now (lines_now),
        .clr       (rd_stat),
        .lines_q   (lines_q),
        .flags     (flags)
    );

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (mdm_sel_e'(addr) == SEL_STAT) rdata[STAT_W-1:0] = {lines_now, flags};
            else                              rdata[CTRL_W-1:0] = ctrl_q;
        end
    end
endmodule

// File: rtl/mdm_ctl_loop_chk.sv
module mdm_ctl_loop_chk
    import mdm_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       wr_ctrl,
    input logic       rd_stat,
    input mdm_ctrl_t  ctrl_q,
    input mdm_lines_t lines_now,
    input mdm_lines_t lines_q,
    input mdm_lines_t flags,
    input logic       tx_ser,
    input logic       rx_ser,
    input logic       txd_pin,
    input logic       dtr_n,
    input logic       rts_n,
    input logic       out1_n,
    input logic       out2_n
);
    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_ctrl |=> $stable(ctrl_q)); // R1

    AST_LOOP_PINS_IDLE: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.loop |-> (dtr_n && rts_n && out1_n && out2_n && txd_pin)); // R6

    AST_LOOP_TURNAROUND: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.loop |-> (rx_ser == tx_ser)); // R7

    AST_CTS_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        (lines_now.cts != lines_q.cts) |=> flags.cts); // R9

    AST_RI_TRAIL_SET: assert property (@(posedge clk) disable iff (rst)
        (lines_q.ri && !lines_now.ri) |=> flags.ri); // R9

    AST_RI_LEAD_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!lines_q.ri && lines_now.ri && !flags.ri) |=> !flags.ri); // R9

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rd_stat && (lines_now == lines_q)) |=> (flags == '0)); // R10
endmodule

bind mdm_ctl_loop mdm_ctl_loop_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_ctrl   (wr_ctrl),
    .rd_stat   (rd_stat),
    .ctrl_q    (ctrl_q),
    .lines_now (lines_now),
    .lines_q   (lines_q),
    .flags     (flags),
    .tx_ser    (tx_ser),
    .rx_ser    (rx_ser),
    .txd_pin   (txd_pin),
    .dtr_n     (dtr_n),
    .rts_n     (rts_n),
    .out1_n    (out1_n),
    .out2_n    (out2_n)
);

// File: tb/sim_mdm_ctl_loop.sv
`timescale 1ns/1ps
module sim_mdm_ctl_loop;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       tx_ser = 1'b1, rxd_pin = 1'b1;
    logic       rx_ser, txd_pin, dtr_n, rts_n, out1_n, out2_n;
    logic       cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdm_ctl_loop u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .tx_ser(tx_ser), .rx_ser(rx_ser),
        .txd_pin(txd_pin), .rxd_pin(rxd_pin), .dtr_n(dtr_n), .rts_n(rts_n),
        .out1_n(out1_n), .out2_n(out2_n), .cts_n(cts_n), .dsr_n(dsr_n),
        .ri_n(ri_n), .dcd_n(dcd_n)
    );

    // Behavioural reference: index 0 cts, 1 dsr, 2 ri, 3 dcd
    logic [4:0] m_ctrl = '0;
    logic [3:0] m_pipe [$];
    logic [3:0] m_prev = '0;
    logic [3:0] m_flag = '0;

    initial begin
        m_pipe.push_back(4'h0);
        m_pipe.push_back(4'h0);
    end

    function automatic logic [3:0] m_now();
        if (m_ctrl[4]) return {m_ctrl[3], m_ctrl[2], m_ctrl[0], m_ctrl[1]};
        return m_pipe[0];
    endfunction

    always @(posedge clk) begin
        logic [3:0] now_v, ev;
        if (rst) begin
            m_ctrl = '0;
            m_prev = '0;
            m_flag = '0;
            m_pipe = {4'h0, 4'h0};
        end else begin
            now_v = m_now();
            for (int i = 0; i < 4; i++)
                ev[i] = (i == 2) ? (m_prev[i] && !now_v[i]) : (m_prev[i] != now_v[i]);
            m_flag = ((rd_en && addr) ? 4'h0 : m_flag) | ev;
            m_prev = now_v;
            void'(m_pipe.pop_front());
            m_pipe.push_back(~{dcd_n, ri_n, dsr_n, cts_n});
            if (wr_en && !addr) m_ctrl = wdata[4:0];
        end
    end

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s at cycle %0d: got %h expected %h", tag, cyc, got, exp);
        end
    endtask

    task automatic compare_all();
        logic lp;
        logic [7:0] exp_rd;
        lp = m_ctrl[4];
        chk(lp ? "R6 dtr_n" : "R2 dtr_n", {7'b0, dtr_n}, {7'b0, lp ? 1'b1 : !m_ctrl[0]});
        chk(lp ? "R6 rts_n" : "R3 rts_n", {7'b0, rts_n}, {7'b0, lp ? 1'b1 : !m_ctrl[1]});
        chk(lp ? "R6 out1_n" : "R4 out1_n", {7'b0, out1_n}, {7'b0, lp ? 1'b1 : !m_ctrl[2]});
        chk(lp ? "R6 out2_n" : "R4 out2_n", {7'b0, out2_n}, {7'b0, lp ? 1'b1 : !m_ctrl[3]});
        chk(lp ? "R6 txd_pin" : "R7 txd_pin", {7'b0, txd_pin}, {7'b0, lp ? 1'b1 : tx_ser});
        chk("R7 rx_ser", {7'b0, rx_ser}, {7'b0, lp ? tx_ser : rxd_pin});
        if (!rd_en)     exp_rd = 8'h00;
        else if (addr)  exp_rd = {m_now(), m_flag};
        else            exp_rd = {3'b0, m_ctrl};
        if (!rd_en)      chk("R11 rdata idle", rdata, exp_rd);
        else if (!addr)  chk("R1 control readback", rdata, exp_rd);
        else if (lp)     chk("R5/R9/R10 status read", rdata, exp_rd);
        else             chk("R8/R9/R10 status read", rdata, exp_rd);
    endtask

    // One cycle: inputs already set after a falling edge
    task automatic tick();
        #1;
        compare_all();
        @(negedge clk);
    endtask

    task automatic idle();
        wr_en = 0; rd_en = 0; addr = 0; wdata = '0;
    endtask

    task automatic wr_ctrl(input logic [7:0] v);
        wr_en = 1; rd_en = 0; addr = 0; wdata = v; tick(); idle();
    endtask

    task automatic rd(input logic a);
        wr_en = 0; rd_en = 1; addr = a; tick(); idle();
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !done) begin
            done = 1'b1;
            bad++;
            total++;
            $display("FAIL watchdog expired after %0d cycles", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk); @(negedge clk);
        // Reset state (R1, R2, R3, R4, R11)
        tick();
        rd(1'b0);
        rst = 0;
        tick(); tick();

        // R1: control writes, upper bits dropped
        wr_ctrl(8'h01); rd(1'b0);
        wr_ctrl(8'h02); rd(1'b0);
        wr_ctrl(8'h0C); rd(1'b0);
        wr_ctrl(8'hE5); rd(1'b0);
        wr_ctrl(8'h00); tick();

        // R8/R9: external pins through the synchroniser
        cts_n = 0; tick(); rd(1'b1); rd(1'b1); rd(1'b1);
        dsr_n = 0; dcd_n = 0; tick(); tick(); tick(); rd(1'b1);
        ri_n = 0; tick(); tick(); tick(); rd(1'b1);   // ring rising: no flag
        ri_n = 1; tick(); tick(); tick(); rd(1'b1);   // ring trailing: flag
        rd(1'b1);

        // R10: change arrives on the same edge as a clearing read
        dcd_n = 1; tick(); tick(); rd(1'b1); rd(1'b1); rd(1'b1);
        cts_n = 1; dsr_n = 1; tick(); tick(); rd(1'b1); rd(1'b1);

        // R7: serial path outside loopback
        tx_ser = 0; rxd_pin = 1; tick();
        tx_ser = 1; rxd_pin = 0; tick();

        // R5/R6/R7: loopback
        wr_ctrl(8'h10); rd(1'b1);
        wr_ctrl(8'h13); rd(1'b1); rd(1'b1);
        wr_ctrl(8'h1C); rd(1'b1);
        wr_en = 1; addr = 0; wdata = 8'h18; tick();         // ring trailing via out1
        wr_en = 0; rd_en = 1; addr = 1; tick(); idle();       // R10 same-edge set
        rd(1'b1); rd(1'b1);
        tx_ser = 0; rxd_pin = 1; cts_n = 0; tick();
        tx_ser = 1; rxd_pin = 0; tick(); tick(); tick(); rd(1'b1);
        wr_ctrl(8'h00); rd(1'b1); rd(1'b1);
        cts_n = 1; rxd_pin = 1;
        tick(); tick(); tick(); rd(1'b1);

        // Mixed traffic against the model
        for (int i = 0; i < 600; i++) begin
            wr_en   = ($urandom % 7) == 0;
            rd_en   = ($urandom % 3) == 0;
            addr    = $urandom % 2;
            wdata   = $urandom % 256;
            tx_ser  = $urandom % 2;
            rxd_pin = $urandom % 2;
            if (($urandom % 5) == 0) cts_n = ~cts_n;
            if (($urandom % 6) == 0) dsr_n = ~dsr_n;
            if (($urandom % 4) == 0) ri_n  = ~ri_n;
            if (($urandom % 7) == 0) dcd_n = ~dcd_n;
            tick();
        end
        idle();
        tick();

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule